// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block is the stepping core of one channel of a legacy-style DMA controller. Software loads a 16-bit start address, an 8-bit page and a 16-bit count that is one less than the number of transfers. Each accepted step strobe then advances the address by one transfer unit and lowers the count by one. The block keeps no data path. It only produces the 24-bit physical bus address, the byte lanes for the current transfer, a terminal count pulse, and a residue in bytes that can be read at any time.

A parameter sets the channel type. A byte channel moves 8-bit units inside a 64 KB window: the page supplies address bits 23:16 and the counter supplies bits 15:0. A word channel moves 16-bit units inside a 128 KB window: it drops page bit 0 and shifts the counter up by one bit. The page never advances, so an address that runs past the top of its window wraps to the bottom of the same window.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset, the physical address is 0 and terminal count is low. The residue reads one unit: 1 on a byte channel, 2 on a word channel.
- R2: Byte channel (WORD_CHAN=0): the physical address is {page[7:0], addr[15:0]}. The lane output is 2'b01 when addr bit 0 is 0 and 2'b10 when addr bit 0 is 1.
- R3: Word channel (WORD_CHAN=1): the physical address is {page[7:1], addr[15:0], 1'b0}, so page bit 0 has no effect. The lane output is always 2'b11.
- R4: Each accepted step adds one to the 16-bit address counter, wrapping from 0xFFFF to 0x0000. Physical bits 23:17 change only on a load.
- R5: Each accepted step lowers the count by one. The residue is ((count + 1) mod 65536) units, which is bytes on a byte channel and twice that on a word channel.
- R6: On the step taken while the count is 0x0000, terminal count is high for exactly the following cycle, and the count becomes 0xFFFF (residue 0). Later steps change nothing until the next load.
- R7: A load copies the base address, count and page into the current registers, clears terminal count and arms the channel. A load in the same cycle as a step wins, and that step is not taken.
- R8: Steps that arrive before the first load are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Copy base values into the current registers and arm the channel |
| base_addr_i | input | 16 | Start address in transfer units |
| base_cnt_i | input | 16 | Number of transfers minus one |
| page_i | input | 8 | Page value (upper address bits) |
| step_i | input | 1 | One transfer has completed |
| phys_addr_o | output | 24 | Physical bus address of the current transfer |
| lane_o | output | 2 | Byte lanes in use |
| tc_o | output | 1 | Terminal count pulse |
| residue_o | output | 17 | Bytes remaining |

## Verification
The hardest conditions to reach are the full-length transfer and the window wrap. The full-length transfer loads a count of 0xFFFF and needs 65536 steps before terminal count appears. The window wrap needs a counter at 0xFFFF that steps while the page stays fixed. Random loads are biased toward addresses just below 0xFFFF and toward short counts, so wraps and terminal counts happen often. One directed run then steps a 0xFFFF count to completion on both channel types. Load-with-step collisions and steps after completion also come up in the random mix, and the bench checks them against its own model of the channel.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;
    localparam int ADDR_W = 16;
    localparam int CNT_W  = 16;
    localparam int PAGE_W = 8;
    localparam int PHYS_W = ADDR_W + PAGE_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        logic [PAGE_W-1:0] page;
        logic              act;
        logic              tc;
    } eng_st_t;
endpackage

// File: rtl/dma_addr_map.sv
module dma_addr_map #(
    parameter int WORD_CHAN = 0,
    parameter int ADDR_W    = 16,
    parameter int PAGE_W    = 8,
    localparam int PHYS_W   = ADDR_W + PAGE_W
) (
    input  logic [PAGE_W-1:0] page_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [PHYS_W-1:0] phys_o,
    output logic [1:0]        lane_o
);
    generate
        if (WORD_CHAN != 0) begin : g_word
            // one address bit is given up to the unit shift; page bit 0 is dropped
            assign phys_o = {page_i[PAGE_W-1:1], addr_i, 1'b0};
            assign lane_o = 2'b11;
        end else begin : g_byte
            assign phys_o = {page_i, addr_i};
            assign lane_o = addr_i[0] ? 2'b10 : 2'b01;
        end
    endgenerate
endmodule

// File: rtl/dma_residue.sv
module dma_residue #(
    parameter int WORD_CHAN = 0,
    parameter int CNT_W     = 16
) (
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W:0]   res_o
);
    logic [CNT_W-1:0] units;
    assign units = cnt_i + 1'b1;

    generate
        if (WORD_CHAN != 0) begin : g_word
            assign res_o = {units, 1'b0};
        end else begin : g_byte
            assign res_o = {1'b0, units};
        end
    endgenerate
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
    import dma_eng_pkg::*;
#(
    parameter int WORD_CHAN = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    input  logic [CNT_W-1:0]  base_cnt_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic              step_i,
    output logic [PHYS_W-1:0] phys_addr_o,
    output logic [1:0]        lane_o,
    output logic              tc_o,
    output logic [CNT_W:0]    residue_o
);
    eng_st_t st_d, st_q;

    logic [ADDR_W-1:0] addr_cur;
    logic [CNT_W-1:0]  cnt_cur;
    logic              act_cur;

    assign addr_cur = st_q.addr;
    assign cnt_cur  = st_q.cnt;
    assign act_cur  = st_q.act;

    always_comb begin
        st_d    = st_q;
        st_d.tc = 1'b0;
        if (load_i) begin
            st_d.addr = base_addr_i;
            st_d.cnt  = base_cnt_i;
            st_d.page = page_i;
            st_d.act  = 1'b1;
        end else if (step_i && st_q.act) begin
            st_d.addr = st_q.addr + 1'b1;
            st_d.cnt  = st_q.cnt - 1'b1;
            if (st_q.cnt == '0) begin
                st_d.tc  = 1'b1;
                st_d.act = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tc_o = st_q.tc;

    dma_addr_map #(
        .WORD_CHAN (WORD_CHAN),
        .ADDR_W    (ADDR_W),
        .PAGE_W    (PAGE_W)
    ) u_map (
        .page_i (st_q.page),
        .addr_i (addr_cur),
        .phys_o (phys_addr_o),
        .lane_o (lane_o)
    );

    dma_residue #(
        .WORD_CHAN (WORD_CHAN),
        .CNT_W     (CNT_W)
    ) u_res (
        .cnt_i (cnt_cur),
        .res_o (residue_o)
    );
endmodule

// File: rtl/dma_xfer_engine_chk.sv
module dma_xfer_engine_chk #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int PHYS_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_i,
    input logic              step_i,
    input logic [ADDR_W-1:0] base_addr_i,
    input logic [CNT_W-1:0]  base_cnt_i,
    input logic              tc_o,
    input logic [PHYS_W-1:0] phys_addr_o,
    input logic              act,
    input logic [ADDR_W-1:0] addr,
    input logic [CNT_W-1:0]  cnt
);
    p_tc_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tc_o |=> !tc_o);

    p_addr_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && act && !load_i) |=> addr == ADDR_W'($past(addr) + 1'b1));

    p_cnt_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && act && !load_i) |=> cnt == CNT_W'($past(cnt) - 1'b1));

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!act && !load_i) |=> ($stable(addr) && $stable(cnt)));

    p_load_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (addr == $past(base_addr_i) && cnt == $past(base_cnt_i) && !tc_o));

    p_page_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(phys_addr_o[PHYS_W-1:ADDR_W+1]));
endmodule

bind dma_xfer_engine dma_xfer_engine_chk #(
    .ADDR_W (dma_eng_pkg::ADDR_W),
    .CNT_W  (dma_eng_pkg::CNT_W),
    .PHYS_W (dma_eng_pkg::PHYS_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_i),
    .step_i      (step_i),
    .base_addr_i (base_addr_i),
    .base_cnt_i  (base_cnt_i),
    .tc_o        (tc_o),
    .phys_addr_o (phys_addr_o),
    .act         (act_cur),
    .addr        (addr_cur),
    .cnt         (cnt_cur)
);

// File: tb/dma_xfer_engine_tb.sv
module dma_xfer_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic        step = 1'b0;
    logic [15:0] baddr = '0;
    logic [15:0] bcnt = '0;
    logic [7:0]  page = '0;

    logic [23:0] phys_b, phys_w;
    logic [1:0]  lane_b, lane_w;
    logic        tc_b, tc_w;
    logic [16:0] res_b, res_w;

    int checks = 0;
    int fails = 0;

    // bench model of the channel
    logic [15:0] m_addr = '0;
    logic [15:0] m_cnt = '0;
    logic [7:0]  m_page = '0;
    logic        m_act = 1'b0;
    logic        m_tc = 1'b0;

    always #5 clk = ~clk;

    dma_xfer_engine #(.WORD_CHAN(0)) u_dut (
        .clk(clk), .rst_n(rst_n), .load_i(load), .base_addr_i(baddr),
        .base_cnt_i(bcnt), .page_i(page), .step_i(step),
        .phys_addr_o(phys_b), .lane_o(lane_b), .tc_o(tc_b), .residue_o(res_b)
    );

    dma_xfer_engine #(.WORD_CHAN(1)) u_dut_w (
        .clk(clk), .rst_n(rst_n), .load_i(load), .base_addr_i(baddr),
        .base_cnt_i(bcnt), .page_i(page), .step_i(step),
        .phys_addr_o(phys_w), .lane_o(lane_w), .tc_o(tc_w), .residue_o(res_w)
    );

    function automatic logic [23:0] exp_phys(input bit word);
        return word ? {m_page[7:1], m_addr, 1'b0} : {m_page, m_addr};
    endfunction

    function automatic logic [16:0] exp_res(input bit word);
        logic [15:0] u;
        u = m_cnt + 16'd1;
        return word ? {u, 1'b0} : {1'b0, u};
    endfunction

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", rq, act, exp, $time);
        end
    endtask

    task automatic check_all();
        chk("R2 R4 byte phys", 32'(phys_b), 32'(exp_phys(0)));
        chk("R2 byte lanes", 32'(lane_b), m_addr[0] ? 32'd2 : 32'd1);
        chk("R6 byte tc", 32'(tc_b), 32'(m_tc));
        chk("R5 byte residue", 32'(res_b), 32'(exp_res(0)));
        chk("R3 R4 word phys", 32'(phys_w), 32'(exp_phys(1)));
        chk("R3 word lanes", 32'(lane_w), 32'd3);
        chk("R6 word tc", 32'(tc_w), 32'(m_tc));
        chk("R5 word residue", 32'(res_w), 32'(exp_res(1)));
    endtask

    // one cycle: drive at falling edge, update model at rising edge, check after it
    task automatic cyc(input bit ld, input logic [15:0] a, input logic [15:0] c,
                       input logic [7:0] p, input bit st, input bit do_chk);
        @(negedge clk);
        load = ld; baddr = a; bcnt = c; page = p; step = st;
        @(posedge clk);
        m_tc = 1'b0;
        if (ld) begin
            m_addr = a; m_cnt = c; m_page = p; m_act = 1'b1;
        end else if (st && m_act) begin
            if (m_cnt == 16'd0) begin
                m_tc = 1'b1; m_act = 1'b0;
            end
            m_addr = m_addr + 16'd1;
            m_cnt  = m_cnt - 16'd1;
        end
        #2;
        if (do_chk) check_all();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R6 run did not finish actual=hung expected=done");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        #12;
        // R1 reset state
        chk("R1 byte phys", 32'(phys_b), 32'd0);
        chk("R1 byte tc", 32'(tc_b), 32'd0);
        chk("R1 byte residue", 32'(res_b), 32'd1);
        chk("R1 word residue", 32'(res_w), 32'd2);
        rst_n = 1'b1;

        // R8 steps before any load are ignored
        for (int i = 0; i < 4; i++) cyc(0, 16'h1234, 16'h5, 8'h33, 1, 1);
        chk("R8 byte residue idle", 32'(res_b), 32'd1);

        // R7 load wins over step; R3 page bit 0 ignored on the word channel
        cyc(1, 16'hFFFE, 16'd2, 8'h5B, 1, 1);
        chk("R7 load copies addr", 32'(phys_b), 32'h5BFFFE);
        chk("R3 word page bit0", 32'(phys_w[23:17]), 32'h2D);
        // R4 wrap inside the window, R6 terminal count
        for (int i = 0; i < 5; i++) cyc(0, '0, '0, '0, 1, 1);
        chk("R4 wrap byte", 32'(phys_b), 32'h5B0001);
        chk("R6 residue zero", 32'(res_b), 32'd0);

        // R6 single transfer with count 0
        cyc(1, 16'h0010, 16'd0, 8'h01, 0, 1);
        cyc(0, '0, '0, '0, 1, 1);
        chk("R6 single tc", 32'(tc_b), 32'd1);
        cyc(0, '0, '0, '0, 1, 1);
        chk("R6 tc one cycle", 32'(tc_b), 32'd0);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            bit ld;
            logic [15:0] a;
            ld = (($urandom % 16) == 0) || (!m_act && (($urandom % 3) == 0));
            a  = ($urandom % 2) ? (16'hFFF0 + 16'($urandom % 16)) : 16'($urandom);
            cyc(ld, a, 16'($urandom % 24), 8'($urandom), ($urandom % 4) != 0, 1);
        end

        // R5 R6 full 65536-transfer run
        cyc(1, 16'h8000, 16'hFFFF, 8'hA7, 0, 1);
        chk("R5 full residue word", 32'(res_w), 32'd0);
        for (int i = 0; i < 65535; i++) cyc(0, '0, '0, '0, 1, 0);
        check_all();
        chk("R6 no tc before last", 32'(tc_b), 32'd0);
        cyc(0, '0, '0, '0, 1, 1);
        chk("R6 full run tc", 32'(tc_b), 32'd1);
        chk("R4 full run back to start", 32'(phys_b), 32'hA78000);
        cyc(0, '0, '0, '0, 1, 1);
        chk("R6 stopped residue", 32'(res_b), 32'd0);

        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule